// File: doc/BRIEF.md
# Double-Buffered Drawing Command Register Bank

This block is the host-facing parameter store of a 2D drawing engine. Software writes the parameters of a drawing operation into a front bank over a simple 32-bit write/read port, with one register every 4 bytes. Writing the launch register at offset 3Ch starts the operation. The front contents are then copied into a back bank that feeds the engine, and the front bank is free at once for the next operation.

One operation can wait behind the running one. A launch written while the engine is busy sets a pending flag. When the engine reports completion, the queued front contents move to the back bank without a gap. The four extra pattern-colour words at offsets 20h to 2Ch are single-buffered: the engine sees the front copy, so rewriting them changes a running operation. The front bank is never locked. Writes made while an operation is queued overwrite the queued values. The engine itself is outside this block and is represented by its `eng_done` pulse.

Top module: `prim_regbank`

## Requirements
- R1: After synchronous reset, every register reads 0, the status word reads 0, `eng_regs` is all zero and `eng_go` is low.
- R2: A write to byte offset 4*i, for i from 0 to 15, stores the data in front word i, and a read of that offset returns it on the same cycle. The status word reads back at offset 44h. Reads of other offsets return 0. Writes to the status word or to unmapped offsets change nothing. Address bits [1:0] are ignored.
- R3: A write to the launch register (offset 3Ch, word 15) while idle does three things at the next edge: it copies every double-buffered front word, including the launch word just written, to the engine view; it sets busy (status bit 0); and it raises `eng_go` for exactly one cycle.
- R4: A launch write while busy and not pending sets pending (status bit 2) and leaves the engine view of the double-buffered words unchanged.
- R5: `eng_done` while pending copies the front bank to the engine view, clears pending, keeps busy set and pulses `eng_go`.
- R6: `eng_done` while busy, not pending and with no launch write clears busy. `eng_done` while idle has no effect. `eng_done` together with a launch write while busy and not pending copies the bank and keeps busy set.
- R7: A launch write while pending already set does not change busy or pending, but its data is stored in front word 15.
- R8: Front-bank writes while an operation is pending overwrite the queued values, and the later transfer carries the newest values.
- R9: Words 8 to 11 (offsets 20h to 2Ch) are single-buffered: `eng_regs` shows a write to them on the cycle after the write, including while busy.
- R10: While busy, and with no `eng_done`, the engine view of the double-buffered words does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte offset |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read byte offset |
| rd_data | output | DATA_W | Host read data (combinational) |
| eng_done | input | 1 | Engine finished the current operation (one-cycle pulse) |
| eng_go | output | 1 | One-cycle pulse: a new operation was loaded into the engine view |
| eng_regs | output | N_WORDS x DATA_W | Engine view: back bank for double-buffered words, front copy for words 8 to 11 |

## Verification
The launch sequencing is driven with directed sequences covering each case. An idle launch shows that the copy includes a same-cycle write. A busy launch shows queueing separately from transfer. A second launch while pending shows that the request is dropped but its data kept. Done with and without a queued operation shows hand-off versus retirement. Seeded random traffic then mixes writes to every offset, including the colour, status and unmapped ones, with random done pulses, and compares each cycle against a bench model. This separates the double-buffered words from the single-buffered ones and catches a transfer at the wrong moment.

// File: rtl/prim_regbank_pkg.sv
package prim_regbank_pkg;

    localparam int unsigned LAUNCH_IDX = 15;
    localparam int unsigned COLOR_LO   = 8;
    localparam int unsigned COLOR_HI   = 11;
    localparam int unsigned STATUS_IDX = 17;
    localparam int unsigned BUSY_BIT   = 0;
    localparam int unsigned PEND_BIT   = 2;

    typedef struct packed {
        logic busy;
        logic pend;
    } seq_state_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_XFER,
        ACT_QUEUE,
        ACT_RETIRE
    } seq_act_t;

    function automatic bit is_pipelined(input int unsigned idx);
        return !(idx >= COLOR_LO && idx <= COLOR_HI);
    endfunction

endpackage

// File: rtl/prb_front.sv
module prb_front #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_WORDS = 16,
    parameter int unsigned IDX_W   = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_hit,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [N_WORDS-1:0][DATA_W-1:0]   slave_q,
    output logic [N_WORDS-1:0][DATA_W-1:0]   slave_nxt
);

    always_comb begin
        for (int i = 0; i < int'(N_WORDS); i++) begin
            slave_nxt[i] = (wr_hit && wr_idx == IDX_W'(i)) ? wr_data : slave_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slave_q <= '0;
        else     slave_q <= slave_nxt;
    end

endmodule

// File: rtl/prb_back.sv
module prb_back
    import prim_regbank_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_WORDS = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             xfer,
    input  logic [N_WORDS-1:0][DATA_W-1:0]   slave_q,
    input  logic [N_WORDS-1:0][DATA_W-1:0]   slave_nxt,
    output logic [N_WORDS-1:0][DATA_W-1:0]   eng_regs
);

    for (genvar g = 0; g < int'(N_WORDS); g++) begin : g_word
        if (is_pipelined(g)) begin : g_dbl
            logic [DATA_W-1:0] master_q;
            always_ff @(posedge clk) begin
                if (rst)       master_q <= '0;
                else if (xfer) master_q <= slave_nxt[g];
            end
            assign eng_regs[g] = master_q;
        end else begin : g_sgl
            assign eng_regs[g] = slave_q[g];
        end
    end

endmodule

// File: rtl/prb_seq.sv
module prb_seq
    import prim_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic done,
    output logic busy,
    output logic pend,
    output logic xfer,
    output logic go
);

    seq_state_t st_q, st_d;
    seq_act_t   act;

    always_comb begin
        act = ACT_NONE;
        if (!st_q.busy) begin
            if (launch) act = ACT_XFER;
        end else if (done) begin
            if (st_q.pend || launch) act = ACT_XFER;
            else                     act = ACT_RETIRE;
        end else if (launch && !st_q.pend) begin
            act = ACT_QUEUE;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_XFER:   begin st_d.busy = 1'b1; st_d.pend = 1'b0; end
            ACT_QUEUE:  st_d.pend = 1'b1;
            ACT_RETIRE: st_d.busy = 1'b0;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            go   <= 1'b0;
        end else begin
            st_q <= st_d;
            go   <= (act == ACT_XFER);
        end
    end

    assign xfer = (act == ACT_XFER);
    assign busy = st_q.busy;
    assign pend = st_q.pend;

endmodule

// File: rtl/prim_regbank.sv
module prim_regbank
    import prim_regbank_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_WORDS = 16,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data,
    input  logic                             eng_done,
    output logic                             eng_go,
    output logic [N_WORDS-1:0][DATA_W-1:0]   eng_regs
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_hit, launch, xfer, busy_q, pend_q;
    logic [N_WORDS-1:0][DATA_W-1:0] slave_q, slave_nxt;
    logic             unused_lane;

    assign wr_idx      = wr_addr[ADDR_W-1:2];
    assign rd_idx      = rd_addr[ADDR_W-1:2];
    assign unused_lane = ^{wr_addr[1:0], rd_addr[1:0]};
    assign wr_hit      = wr_en && (wr_idx < IDX_W'(N_WORDS));
    assign launch      = wr_en && (wr_idx == IDX_W'(LAUNCH_IDX));

    prb_front #(.DATA_W(DATA_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_front (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_idx(wr_idx),
        .wr_data(wr_data), .slave_q(slave_q), .slave_nxt(slave_nxt)
    );

    prb_back #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_back (
        .clk(clk), .rst(rst), .xfer(xfer), .slave_q(slave_q),
        .slave_nxt(slave_nxt), .eng_regs(eng_regs)
    );

    prb_seq u_seq (
        .clk(clk), .rst(rst), .launch(launch), .done(eng_done),
        .busy(busy_q), .pend(pend_q), .xfer(xfer), .go(eng_go)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(N_WORDS); i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slave_q[i];
        end
        if (rd_idx == IDX_W'(STATUS_IDX)) begin
            rd_data[BUSY_BIT] = busy_q;
            rd_data[PEND_BIT] = pend_q;
        end
    end

endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              launch,
    input logic              done,
    input logic              busy,
    input logic              pend,
    input logic              go,
    input logic [DATA_W-1:0] eng_first,
    input logic [DATA_W-1:0] eng_launch
);

    a_r3_idle_launch: assert property (@(posedge clk) disable iff (rst)
        (!busy && launch) |=> (busy && go));

    a_r4_busy_queue: assert property (@(posedge clk) disable iff (rst)
        (busy && !pend && launch && !done) |=> (busy && pend && $stable(eng_first)));

    a_r5_handoff: assert property (@(posedge clk) disable iff (rst)
        (busy && pend && done) |=> (busy && !pend && go));

    a_r6_retire: assert property (@(posedge clk) disable iff (rst)
        (busy && !pend && done && !launch) |=> (!busy && !go));

    a_r6_idle_done: assert property (@(posedge clk) disable iff (rst)
        (!busy && !launch) |=> (!busy && !go));

    a_r7_pend_hold: assert property (@(posedge clk) disable iff (rst)
        (pend && !done) |=> pend);

    a_r7_pend_busy: assert property (@(posedge clk) disable iff (rst)
        pend |-> busy);

    a_r10_view_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(eng_first) && $stable(eng_launch) && !go));

endmodule

bind prim_regbank prb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .launch(launch), .done(eng_done),
    .busy(busy_q), .pend(pend_q), .go(eng_go),
    .eng_first(eng_regs[0]), .eng_launch(eng_regs[15])
);

// File: tb/prim_regbank_test.sv
module prim_regbank_test;

    localparam int DW = 32;
    localparam int NW = 16;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic              eng_done = 1'b0;
    logic              eng_go;
    logic [NW-1:0][DW-1:0] eng_regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [DW-1:0] m_slave  [NW];
    logic [DW-1:0] m_master [NW];
    bit            m_busy, m_pend, m_go;

    prim_regbank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_done(eng_done), .eng_go(eng_go), .eng_regs(eng_regs)
    );

    always #10ns clk = ~clk;

    function automatic bit dbl(input int i);
        return (i < 8) || (i > 11);
    endfunction

    function automatic logic [DW-1:0] exp_eng(input int i);
        return dbl(i) ? m_master[i] : m_slave[i];
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NW; i++) begin m_slave[i] = '0; m_master[i] = '0; end
        m_busy = 0; m_pend = 0; m_go = 0;
    endtask

    task automatic model_edge(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit dn);
        int  idx = int'(a[AW-1:2]);
        bit  st  = we && idx == 15;
        bit  xf  = 0;
        if (we && idx < NW) m_slave[idx] = d;
        if (!m_busy) begin
            if (st) begin xf = 1; m_busy = 1; end
        end else if (dn) begin
            if (m_pend || st) begin xf = 1; m_pend = 0; end
            else m_busy = 0;
        end else if (st) m_pend = 1;
        m_go = xf;
        if (xf) for (int i = 0; i < NW; i++) if (dbl(i)) m_master[i] = m_slave[i];
    endtask

    task automatic compare_all(input string tag);
        logic [NW-1:0][DW-1:0] ev;
        for (int i = 0; i < NW; i++) ev[i] = exp_eng(i);
        n_checks++;
        if (eng_regs !== ev) begin
            n_fail++;
            $display("FAIL %s eng_regs: actual %h expected %h", tag, eng_regs, ev);
        end
        check({tag, " eng_go"}, {31'b0, eng_go}, {31'b0, m_go});
        rd_addr = 8'h44;
        #1ns;
        check({tag, " status"}, rd_data, {29'b0, m_pend, 1'b0, m_busy});
    endtask

    task automatic step(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit dn, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; eng_done = dn;
        @(posedge clk);
        model_edge(we, a, d, dn);
        #1ns;
        wr_en = 0; eng_done = 0;
        compare_all(tag);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1ns;
        check(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1ns;
        compare_all("R1 reset");
        rd_check(8'h0C, 32'h0, "R1 word3 after reset");

        // R2: fill words 0..14 and read back
        for (int i = 0; i < 15; i++) step(1, AW'(i * 4), 32'hA000_0000 + i, 0, "R2 write");
        for (int i = 0; i < 15; i++) rd_check(AW'(i * 4 + (i % 4)), 32'hA000_0000 + i, "R2 readback");
        step(1, 8'h44, 32'hFFFF_FFFF, 0, "R2 status write ignored");
        step(1, 8'h48, 32'h1234_5678, 0, "R2 unmapped write ignored");
        rd_check(8'h48, 32'h0, "R2 unmapped read");
        for (int i = 0; i < NW; i++) check("R2 view unchanged before launch", eng_regs[i], exp_eng(i));

        // R3: idle launch includes same-cycle launch word
        step(1, 8'h3C, 32'h0000_00F1, 0, "R3 idle launch");
        check("R3 launch word in view", eng_regs[15], 32'h0000_00F1);
        check("R3 word0 copied", eng_regs[0], 32'hA000_0000);
        step(0, 8'h0, 32'h0, 0, "R3 go one cycle");

        // R9: colour word live while busy
        step(1, 8'h20, 32'hC0C0_0001, 0, "R9 colour while busy");
        check("R9 colour visible", eng_regs[8], 32'hC0C0_0001);

        // R4: queue behind busy
        step(1, 8'h00, 32'hB000_0000, 0, "R4 front write");
        step(1, 8'h3C, 32'h0000_00F2, 0, "R4 busy launch queues");
        check("R4 view word0 held", eng_regs[0], 32'hA000_0000);

        // R8 / R7
        step(1, 8'h00, 32'hB000_0001, 0, "R8 overwrite queued");
        step(1, 8'h3C, 32'h0000_00F3, 0, "R7 launch while pending");
        rd_check(8'h3C, 32'h0000_00F3, "R7 launch data kept");

        // R10: idle cycles while busy
        for (int i = 0; i < 3; i++) step(0, 8'h0, 32'h0, 0, "R10 hold while busy");

        // R5: hand-off
        step(0, 8'h0, 32'h0, 1, "R5 done with pending");
        check("R5/R8 newest word0", eng_regs[0], 32'hB000_0001);
        check("R5 newest launch word", eng_regs[15], 32'h0000_00F3);

        // R6: retire, then done while idle
        step(0, 8'h0, 32'h0, 1, "R6 retire");
        step(0, 8'h0, 32'h0, 1, "R6 done while idle");
        step(1, 8'h3C, 32'h0000_00F4, 0, "R3 second idle launch");
        step(1, 8'h3C, 32'h0000_00F5, 1, "R6 done with launch keeps busy");
        step(0, 8'h0, 32'h0, 1, "R6 retire again");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit            we = ($urandom_range(0, 3) != 0);
            int            w  = $urandom_range(0, 19);
            logic [DW-1:0] d  = $urandom();
            bit            dn = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 5) == 0) w = 15;
            step(we, AW'(w * 4 + $urandom_range(0, 3)), d, dn,
                 (w >= 8 && w <= 11) ? "R9 random" : "R10 random");
        end

        finish_run();
    end

endmodule